// File: doc/BRIEF.md
# Timer Compare Channels with Pulse Output

This block holds a set of compare channels that watch a free-running timestamp counter. The counter lives elsewhere. Each channel keeps a control word and a compare value, and it drives one output pin. When the counter reaches the channel's armed compare value, the channel does three things. It performs the pin action chosen by its mode, it latches an event flag, and it raises its interrupt if interrupts are enabled for that channel.

The compare value is double-buffered. The first value written arms the channel. A value written after that is held as the next compare, and it takes over automatically at the following match. A periodic output, such as one pulse per second, therefore needs only one compare write per event: software writes the event after the one that is currently armed. Changing the mode also has a fixed order. The mode must first be cleared to zero, and only then can a different nonzero mode be set.

Register access is a plain single-cycle write port, addressed by channel and by register (control or compare). The addressed register is always presented combinationally on the read bus. The block has no streaming data path, so no valid/ready handshake is involved and there is no back-pressure.

Top module: `cmp_pulse_timer`

## Requirements
- R1: After reset, every control word, every compare value and every next-compare slot is zero, and all pins and interrupts are low.
- R2: The control word has this bit layout: bit 0 is the DMA-request enable (stored and read back only), bits 5:2 are the mode, bit 6 is the interrupt enable, bit 7 is the event flag, and bit 1 reads as zero. With reg_sel=0 the read bus shows the control word of channel reg_ch, zero-extended. With reg_sel=1 it shows that channel's active compare value.
- R3: In mode 0x5, a match inverts the pin. The new level appears one cycle after the match cycle. Without a match the pin holds its level.
- R4: In mode 0xF, the pin is high for exactly the one cycle after each match cycle and is low otherwise. Matches in consecutive cycles keep the pin high.
- R5: A match is declared when all of the following hold: the mode is nonzero, a compare value is armed, cnt_tick=1, and cnt_val equals the active compare. A match sets the flag in the next cycle. Writing the control word with bit 7 set clears the flag, but a match in the same cycle wins. In nonzero modes other than 0x5 and 0xF, a match sets only the flag.
- R6: irq_o[i] is high exactly when the flag and the interrupt enable of channel i are both set.
- R7: A compare write while no compare is armed arms the active compare. A compare write while one is armed loads the next slot, overwriting any earlier value there. At a match, a held next value becomes the active compare.
- R8: If the next slot is empty at a match, the channel disarms. The active value stays visible, but no further matches occur until a new compare write arms the channel again.
- R9: A write of a nonzero mode is ignored when the current mode is nonzero and different; the other control bits still update. Writing mode 0 disables the channel: the pin goes low and both compare slots are disarmed.
- R10: In a cycle with cnt_wrap=1, a match is suppressed unless wrap_match_en=1.
- R11: A write changes only the channel selected by reg_ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_ch | input | CH_W | Channel index for the write and the read |
| reg_sel | input | 1 | Register select: 0 selects control, 1 selects compare |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Addressed register contents |
| cnt_val | input | CNT_W | Current timestamp counter value |
| cnt_tick | input | 1 | The counter presents a new value this cycle |
| cnt_wrap | input | 1 | The counter wrapped at its period this cycle |
| wrap_match_en | input | 1 | Allows matches in a wrap cycle |
| pin_o | output | NUM_CH | Channel output pins |
| irq_o | output | NUM_CH | Channel interrupt requests |

## Verification
The bench builds the block with NUM_CH=4, so the address decode is exercised over every channel index, and it uses CNT_W=16. Counter values are kept below 64 so that random compare values are matched often. In that range, back-to-back matches, a match in the same cycle as a flag clear or a mode clear, wrap-cycle suppression, and an empty next slot all occur many times in a few thousand cycles.

// File: rtl/cmp_pulse_pkg.sv
package cmp_pulse_pkg;
  localparam int MODE_W = 4;
  localparam int CTRL_W = 8;
  localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
  localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
  localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;

  // control word as seen on the read bus, bit 7 down to bit 0
  typedef struct packed {
    logic              flag;
    logic              irq_en;
    logic [MODE_W-1:0] mode;
    logic              rsvd;
    logic              dma_en;
  } ctrl_t;
endpackage

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_pulse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_dma,
  input  logic              wr_ie,
  input  logic              wr_clr,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              match,
  output logic              dma_en,
  output logic              irq_en,
  output logic [MODE_W-1:0] mode,
  output logic              flag,
  output logic              mode_clr
);
  logic              dma_d, ie_d, flag_d;
  logic [MODE_W-1:0] mode_d;
  logic              mode_ok;

  assign mode_clr = wr_ctrl && (wr_mode == MODE_OFF);
  // a new nonzero mode only lands on a disabled channel (or restates itself)
  assign mode_ok  = (wr_mode == MODE_OFF) || (mode == MODE_OFF) || (wr_mode == mode);

  always_comb begin
    dma_d  = dma_en;
    ie_d   = irq_en;
    mode_d = mode;
    flag_d = flag;
    if (wr_ctrl) begin
      dma_d = wr_dma;
      ie_d  = wr_ie;
      if (mode_ok) mode_d = wr_mode;
      if (wr_clr)  flag_d = 1'b0;
    end
    if (match) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en <= 1'b0;
      irq_en <= 1'b0;
      mode   <= MODE_OFF;
      flag   <= 1'b0;
    end else begin
      dma_en <= dma_d;
      irq_en <= ie_d;
      mode   <= mode_d;
      flag   <= flag_d;
    end
  end
endmodule

// File: rtl/cmp_dbuf.sv
module cmp_dbuf #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_on,
  input  logic             mode_clr,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_tick,
  input  logic             cnt_wrap,
  input  logic             wrap_en,
  output logic             match,
  output logic [CNT_W-1:0] active_cmp
);
  logic             armed, nxt_vld;
  logic [CNT_W-1:0] nxt_cmp;
  logic             armed_d, nxt_vld_d;
  logic [CNT_W-1:0] act_d, nxt_d;

  assign match = mode_on && armed && cnt_tick && (cnt_val == active_cmp) &&
                 (!cnt_wrap || wrap_en);

  always_comb begin
    act_d     = active_cmp;
    armed_d   = armed;
    nxt_d     = nxt_cmp;
    nxt_vld_d = nxt_vld;
    if (match) begin
      if (nxt_vld) begin
        act_d     = nxt_cmp;
        nxt_vld_d = 1'b0;
      end else begin
        armed_d = 1'b0;
      end
    end
    if (mode_clr) begin
      armed_d   = 1'b0;
      nxt_vld_d = 1'b0;
    end else if (wr_cmp) begin
      if (!armed_d) begin
        act_d   = wdata;
        armed_d = 1'b1;
      end else begin
        nxt_d     = wdata;
        nxt_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_cmp <= '0;
      armed      <= 1'b0;
      nxt_cmp    <= '0;
      nxt_vld    <= 1'b0;
    end else begin
      active_cmp <= act_d;
      armed      <= armed_d;
      nxt_cmp    <= nxt_d;
      nxt_vld    <= nxt_vld_d;
    end
  end
endmodule

// File: rtl/cmp_pin_drv.sv
module cmp_pin_drv
  import cmp_pulse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              match,
  input  logic              mode_clr,
  output logic              pin
);
  logic pin_d;

  always_comb begin
    pin_d = pin;
    if (mode_clr) begin
      pin_d = 1'b0;
    end else begin
      case (mode)
        MODE_PULSE:  pin_d = match;
        MODE_TOGGLE: if (match) pin_d = !pin;
        default:     pin_d = pin;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_d;
  end
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pulse_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cmp,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_tick,
  input  logic              cnt_wrap,
  input  logic              wrap_en,
  output logic              pin,
  output logic              match,
  output ctrl_t             ctrl_rb,
  output logic [CNT_W-1:0]  active_cmp
);
  logic              dma_en, irq_en, flag, mode_clr;
  logic [MODE_W-1:0] mode;
  ctrl_t             wr_word;

  assign wr_word = ctrl_t'(wdata[CTRL_W-1:0]);

  cmp_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_dma   (wr_word.dma_en),
    .wr_ie    (wr_word.irq_en),
    .wr_clr   (wr_word.flag),
    .wr_mode  (wr_word.mode),
    .match    (match),
    .dma_en   (dma_en),
    .irq_en   (irq_en),
    .mode     (mode),
    .flag     (flag),
    .mode_clr (mode_clr)
  );

  cmp_dbuf #(.CNT_W(CNT_W)) u_dbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_on    (mode != MODE_OFF),
    .mode_clr   (mode_clr),
    .wr_cmp     (wr_cmp),
    .wdata      (wdata),
    .cnt_val    (cnt_val),
    .cnt_tick   (cnt_tick),
    .cnt_wrap   (cnt_wrap),
    .wrap_en    (wrap_en),
    .match      (match),
    .active_cmp (active_cmp)
  );

  cmp_pin_drv u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .match    (match),
    .mode_clr (mode_clr),
    .pin      (pin)
  );

  always_comb begin
    ctrl_rb        = '0;
    ctrl_rb.flag   = flag;
    ctrl_rb.irq_en = irq_en;
    ctrl_rb.mode   = mode;
    ctrl_rb.dma_en = dma_en;
  end
endmodule

// File: rtl/cmp_pulse_timer.sv
module cmp_pulse_timer
  import cmp_pulse_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CH_W-1:0]   reg_ch,
  input  logic              reg_sel,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_tick,
  input  logic              cnt_wrap,
  input  logic              wrap_match_en,
  output logic [NUM_CH-1:0] pin_o,
  output logic [NUM_CH-1:0] irq_o
);
  ctrl_t                    ctrl_v [NUM_CH];
  logic [CNT_W-1:0]         cmp_v  [NUM_CH];
  logic [NUM_CH-1:0]        match_v, flag_v, ie_v;
  logic [NUM_CH*MODE_W-1:0] mode_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel_hit;
    assign sel_hit = reg_wr && (reg_ch == CH_W'(i));

    cmp_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (sel_hit && !reg_sel),
      .wr_cmp     (sel_hit && reg_sel),
      .wdata      (reg_wdata),
      .cnt_val    (cnt_val),
      .cnt_tick   (cnt_tick),
      .cnt_wrap   (cnt_wrap),
      .wrap_en    (wrap_match_en),
      .pin        (pin_o[i]),
      .match      (match_v[i]),
      .ctrl_rb    (ctrl_v[i]),
      .active_cmp (cmp_v[i])
    );

    assign flag_v[i]                 = ctrl_v[i].flag;
    assign ie_v[i]                   = ctrl_v[i].irq_en;
    assign mode_v[i*MODE_W +: MODE_W] = ctrl_v[i].mode;
  end

  assign irq_o = flag_v & ie_v;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_ch == CH_W'(i)) begin
        reg_rdata = reg_sel ? cmp_v[i] : CNT_W'(ctrl_v[i]);
      end
    end
  end
endmodule

module cmp_pulse_timer_chk #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [NUM_CH-1:0]   pin_o,
  input logic [NUM_CH-1:0]   match_v,
  input logic [NUM_CH-1:0]   flag_v,
  input logic [NUM_CH*4-1:0] mode_v
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    logic [3:0] md;
    assign md = mode_v[i*4 +: 4];

    a_r5_flag_after_match: assert property (@(posedge clk) disable iff (!rst_n)
      match_v[i] |=> flag_v[i]);

    a_r3_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 4'h5 && match_v[i] && !reg_wr) |=> (pin_o[i] != $past(pin_o[i])));

    a_r3_hold_without_match: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 4'h5 && !match_v[i] && !reg_wr) |=> $stable(pin_o[i]));

    a_r4_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 4'hF && pin_o[i] && !match_v[i]) |=> !pin_o[i]);

    a_r9_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 4'h0) |-> (!match_v[i] && !pin_o[i]));
  end
endmodule

bind cmp_pulse_timer cmp_pulse_timer_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_cmp_pulse_timer.sv
module test_cmp_pulse_timer;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_ch = '0;
  logic          reg_sel = 1'b0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic [CW-1:0] cnt_val = '0;
  logic          cnt_tick = 1'b0;
  logic          cnt_wrap = 1'b0;
  logic          wrap_match_en = 1'b0;
  logic [NCH-1:0] pin_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cmp_pulse_timer #(.NUM_CH(NCH), .CNT_W(CW)) i_cmp_pulse_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_val(cnt_val),
    .cnt_tick(cnt_tick), .cnt_wrap(cnt_wrap), .wrap_match_en(wrap_match_en),
    .pin_o(pin_o), .irq_o(irq_o)
  );

  // requirement-level model state
  logic [3:0]    m_mode [NCH];
  bit            m_dma [NCH], m_ie [NCH], m_flag [NCH], m_ld [NCH], m_nv [NCH], m_pin [NCH];
  logic [CW-1:0] m_act [NCH], m_nxt [NCH];

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic bit exp_match(int i, bit tick, logic [CW-1:0] cv, bit wrap, bit wen);
    return (m_mode[i] != 4'h0) && m_ld[i] && tick && (cv == m_act[i]) && (!wrap || wen);
  endfunction

  function automatic logic [CW-1:0] exp_rdata(int ch, bit sel);
    if (sel) return m_act[ch];
    return {8'h00, m_flag[ch], m_ie[ch], m_mode[ch], 1'b0, m_dma[ch]};
  endfunction

  task automatic step(bit wr, bit [1:0] ch, bit sel, logic [CW-1:0] wd,
                      bit tick, logic [CW-1:0] cv, bit wrap, bit wen, string tag);
    @(negedge clk);
    reg_wr = wr; reg_ch = ch; reg_sel = sel; reg_wdata = wd;
    cnt_tick = tick; cnt_val = cv; cnt_wrap = wrap; wrap_match_en = wen;
    #1;
    chk("R2", "rdata", 32'(reg_rdata), 32'(exp_rdata(ch, sel)));
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      bit mt, np, nf;
      logic [3:0] nm;
      mt = exp_match(i, tick, cv, wrap, wen);
      np = m_pin[i];
      if (m_mode[i] == 4'hF) np = mt;
      else if (m_mode[i] == 4'h5 && mt) np = !m_pin[i];
      nf = m_flag[i] | mt;
      if (mt) begin
        if (m_nv[i]) begin m_act[i] = m_nxt[i]; m_nv[i] = 1'b0; end
        else m_ld[i] = 1'b0;
      end
      if (wr && ch == 2'(i)) begin
        if (!sel) begin
          m_dma[i] = wd[0];
          m_ie[i]  = wd[6];
          if (wd[7] && !mt) nf = 1'b0;
          nm = wd[5:2];
          if (nm == 4'h0) begin
            m_mode[i] = 4'h0; m_ld[i] = 1'b0; m_nv[i] = 1'b0; np = 1'b0;
          end else if (m_mode[i] == 4'h0 || nm == m_mode[i]) begin
            m_mode[i] = nm;
          end
        end else if (!m_ld[i]) begin
          m_act[i] = wd; m_ld[i] = 1'b1;
        end else begin
          m_nxt[i] = wd; m_nv[i] = 1'b1;
        end
      end
      m_pin[i]  = np;
      m_flag[i] = nf;
    end
    #1;
    for (int i = 0; i < NCH; i++) begin
      chk(tag, "pin", 32'(pin_o[i]), 32'(m_pin[i]));
      chk("R6", "irq", 32'(irq_o[i]), 32'(m_flag[i] & m_ie[i]));
    end
  endtask

  task automatic wr_ctrl(bit [1:0] ch, logic [CW-1:0] v, string tag);
    step(1'b1, ch, 1'b0, v, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr_cmp(bit [1:0] ch, logic [CW-1:0] v, string tag);
    step(1'b1, ch, 1'b1, v, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic run(bit [1:0] ch, bit sel, int from, int upto, string tag);
    for (int v = from; v <= upto; v++) step(1'b0, ch, sel, '0, 1'b1, CW'(v), 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin
      m_mode[i] = '0; m_dma[i] = 0; m_ie[i] = 0; m_flag[i] = 0;
      m_ld[i] = 0; m_nv[i] = 0; m_pin[i] = 0; m_act[i] = '0; m_nxt[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "pins", 32'(pin_o), 32'h0);
    chk("R1", "irqs", 32'(irq_o), 32'h0);
    chk("R1", "ctrl0", 32'(reg_rdata), 32'h0);

    // toggle mode with a queued next compare
    wr_cmp(2'd0, 16'd10, "R7");
    wr_ctrl(2'd0, 16'h0054, "R2");
    chk("R2", "ctrl readback", 32'(reg_rdata), 32'h54);
    wr_cmp(2'd0, 16'd20, "R7");
    run(2'd0, 1'b1, 8, 10, "R3");
    chk("R3", "toggle high", 32'(pin_o[0]), 32'h1);
    chk("R6", "irq on flag", 32'(irq_o[0]), 32'h1);
    chk("R7", "next promoted", 32'(reg_rdata), 32'd20);
    run(2'd0, 1'b1, 11, 20, "R3");
    chk("R3", "toggle low", 32'(pin_o[0]), 32'h0);
    run(2'd0, 1'b1, 0, 22, "R8");
    chk("R8", "disarmed no toggle", 32'(pin_o[0]), 32'h0);
    wr_cmp(2'd0, 16'd30, "R8");
    chk("R8", "rearm active", 32'(reg_rdata), 32'd30);
    run(2'd0, 1'b1, 29, 30, "R8");
    chk("R8", "rearmed match", 32'(pin_o[0]), 32'h1);

    // flag clear and mode guard
    wr_ctrl(2'd0, 16'h00D4, "R5");
    chk("R5", "flag cleared", 32'(reg_rdata), 32'h54);
    chk("R6", "irq dropped", 32'(irq_o[0]), 32'h0);
    wr_ctrl(2'd0, 16'h007C, "R9");
    chk("R9", "mode change ignored", 32'(reg_rdata), 32'h54);
    wr_ctrl(2'd0, 16'h0000, "R9");
    chk("R9", "pin low on disable", 32'(pin_o[0]), 32'h0);
    chk("R9", "mode cleared", 32'(reg_rdata), 32'h0);

    // high pulse mode, back-to-back matches
    wr_cmp(2'd2, 16'd5, "R7");
    wr_ctrl(2'd2, 16'h003C, "R4");
    wr_cmp(2'd2, 16'd6, "R7");
    run(2'd2, 1'b0, 4, 5, "R4");
    chk("R4", "pulse high", 32'(pin_o[2]), 32'h1);
    run(2'd2, 1'b0, 6, 6, "R4");
    chk("R4", "pulse held by second match", 32'(pin_o[2]), 32'h1);
    run(2'd2, 1'b0, 7, 7, "R4");
    chk("R4", "pulse ends", 32'(pin_o[2]), 32'h0);
    chk("R5", "flag set ie off", 32'(reg_rdata), 32'hBC);
    chk("R6", "no irq when disabled", 32'(irq_o[2]), 32'h0);

    // wrap cycle gating
    wr_cmp(2'd3, 16'd40, "R10");
    wr_ctrl(2'd3, 16'h0014, "R10");
    step(1'b0, 2'd3, 1'b0, '0, 1'b1, 16'd40, 1'b1, 1'b0, "R10");
    chk("R10", "wrap suppressed", 32'(pin_o[3]), 32'h0);
    chk("R10", "no flag on wrap", 32'(reg_rdata), 32'h14);
    step(1'b0, 2'd3, 1'b0, '0, 1'b1, 16'd40, 1'b1, 1'b1, "R10");
    chk("R10", "wrap allowed", 32'(pin_o[3]), 32'h1);
    chk("R10", "flag on wrap", 32'(reg_rdata), 32'h94);

    // other channels untouched
    step(1'b0, 2'd2, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R11");
    chk("R11", "ch2 unchanged", 32'(reg_rdata), 32'hBC);
    step(1'b0, 2'd0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R11");
    chk("R11", "ch0 unchanged", 32'(reg_rdata), 32'h0);

    // random mix against the model
    begin
      int cnt = 0;
      bit wen = 0;
      for (int n = 0; n < 4000; n++) begin
        bit wr, sel, tick;
        bit [1:0] ch;
        logic [CW-1:0] wd;
        logic [3:0] md;
        wr   = ($urandom % 8) == 0;
        ch   = 2'($urandom % 4);
        sel  = 1'($urandom % 2);
        tick = ($urandom % 4) != 0;
        case ($urandom % 4)
          0: md = 4'h0;
          1: md = 4'h5;
          2: md = 4'hF;
          default: md = 4'h3;
        endcase
        if (sel) wd = CW'($urandom % 64);
        else wd = {8'h00, 1'($urandom % 2), 1'($urandom % 2), md, 1'b0, 1'($urandom % 2)};
        if (($urandom % 32) == 0) wen = !wen;
        step(wr, ch, sel, wd, tick, CW'(cnt), tick && (cnt == 0), wen, "R3 R4 R5 R7 R8 R9 R10");
        if (tick) cnt = (cnt + 1) % 64;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule